// File: doc/BRIEF.md
# Remote Upgrade Reconfiguration Sequencer

This block is user logic that sits beside a flash-based configuration loader and drives two of the loader's inputs: a 3-bit image page select and an active-low reconfigure request. After reset it presents the page of the initial image and leaves the request released. There are two ways to start a reconfiguration. A remote host can report that it has finished writing a new image and name the target page. A watchdog can report a timeout, and in that case the block falls back to a fixed recovery page.

Each accepted request runs the same sequence. The page select takes the new value first. One cycle later the reconfigure request drops low and stays low for a fixed number of cycles, then returns high. A busy flag covers the whole sequence, and any request that arrives while busy is high is dropped. If both sources request in the same cycle, the watchdog fallback wins.

Top module: `reconf_sequencer`

## Requirements
- R1: While reset is active and right after it, `page_sel` equals `INIT_PAGE`, `reconf_n` is 1 and `busy` is 0.
- R2: When `upd_done` is 1 and `wdog_err` is 0 at a clock edge while `busy` is 0, `page_sel` takes the value of `upd_page` after that edge, and `busy` rises at the same time.
- R3: When `wdog_err` is 1 at a clock edge while `busy` is 0, `page_sel` becomes `RECOVERY_PAGE` after that edge, and `busy` rises at the same time.
- R4: `reconf_n` falls one clock after `page_sel` is updated. It then stays 0 for exactly `PULSE_LEN` cycles (default 4) and returns to 1.
- R5: `page_sel` does not change while `busy` is 1, so it is stable for the cycle before the pulse and for the whole pulse.
- R6: When `wdog_err` and `upd_done` are both 1 at the same accepting edge, `page_sel` becomes `RECOVERY_PAGE` and `upd_page` is ignored.
- R7: `RECOVERY_PAGE` defaults to page 0 and `INIT_PAGE` defaults to page 1.
- R8: `busy` is 1 from the cycle after a request is accepted until the cycle in which `reconf_n` returns to 1, and it falls in that cycle. A request seen at an edge while `busy` is 1 has no effect: it changes neither `page_sel` nor the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the loader domain |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_done | input | 1 | Host reports that the new image is written |
| upd_page | input | 3 | Page that holds the new image |
| wdog_err | input | 1 | Watchdog timeout, active high |
| page_sel | output | 3 | Image page select to the loader |
| reconf_n | output | 1 | Reconfigure request, active low |
| busy | output | 1 | A reconfigure sequence is in progress |

## Verification
A corrupted phase or counter shows up at the ports within a few cycles. The request pulse would be too short, too long, or missing, or `busy` would fall out of step with the release of `reconf_n`. A wrong captured page appears on `page_sel` one cycle after the request, before the pulse starts. Because of this, the reference model in the bench compares all three outputs on every cycle, so a divergence is caught in the first cycle it appears. Directed cases cover simultaneous requests, requests made while busy, and requests made right after busy falls.

// File: rtl/reconf_sequencer.sv
module reconf_sequencer #(
  parameter int PAGE_W        = 3,
  parameter int INIT_PAGE     = 1,
  parameter int RECOVERY_PAGE = 0,
  parameter int PULSE_LEN     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_done,
  input  logic [PAGE_W-1:0] upd_page,
  input  logic              wdog_err,
  output logic [PAGE_W-1:0] page_sel,
  output logic              reconf_n,
  output logic              busy
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);

  typedef enum logic [1:0] {IDLE, ARM, FIRE} phase_t;

  phase_t           phase;
  logic [CNT_W-1:0] left;

  assign busy = (phase != IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= IDLE;
      page_sel <= PAGE_W'(INIT_PAGE);
      reconf_n <= 1'b1;
      left     <= '0;
    end else begin
      case (phase)
        IDLE: begin
          if (wdog_err) begin
            page_sel <= PAGE_W'(RECOVERY_PAGE);
            phase    <= ARM;
          end else if (upd_done) begin
            page_sel <= upd_page;
            phase    <= ARM;
          end
        end
        ARM: begin
          reconf_n <= 1'b0;
          left     <= CNT_W'(PULSE_LEN - 1);
          phase    <= FIRE;
        end
        FIRE: begin
          if (left == '0) begin
            reconf_n <= 1'b1;
            phase    <= IDLE;
          end else begin
            left <= left - 1'b1;
          end
        end
        default: phase <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/reconf_sequencer_chk.sv
module reconf_sequencer_chk #(
  parameter int PAGE_W        = 3,
  parameter int RECOVERY_PAGE = 0,
  parameter int PULSE_LEN     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upd_done,
  input logic [PAGE_W-1:0] upd_page,
  input logic              wdog_err,
  input logic [PAGE_W-1:0] page_sel,
  input logic              reconf_n,
  input logic              busy
);
  int unsigned low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= 0;
    else if (!reconf_n) low_cnt <= low_cnt + 1;
    else low_cnt <= 0;
  end

  assert_upd_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && upd_done && !wdog_err) |=> (busy && page_sel == $past(upd_page)));

  assert_wdog_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wdog_err) |=> (busy && page_sel == PAGE_W'(RECOVERY_PAGE)));

  assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reconf_n) |-> (low_cnt == PULSE_LEN));

  assert_pulse_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !reconf_n |-> (low_cnt < PULSE_LEN));

  assert_pulse_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> !reconf_n);

  assert_page_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(page_sel));

  assert_low_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !reconf_n |-> busy);

  assert_busy_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $rose(reconf_n));
endmodule

bind reconf_sequencer reconf_sequencer_chk #(
  .PAGE_W(PAGE_W), .RECOVERY_PAGE(RECOVERY_PAGE), .PULSE_LEN(PULSE_LEN)
) chk_i (
  .clk(clk), .rst_n(rst_n), .upd_done(upd_done), .upd_page(upd_page),
  .wdog_err(wdog_err), .page_sel(page_sel), .reconf_n(reconf_n), .busy(busy)
);

// File: tb/reconf_sequencer_tb_top.sv
module reconf_sequencer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       upd_done = 1'b0;
  logic [2:0] upd_page = 3'd0;
  logic       wdog_err = 1'b0;
  logic [2:0] page_sel;
  logic       reconf_n;
  logic       busy;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  bit cmp_on = 1'b0;

  int m_page;
  int m_phase;
  int lows;

  always #10 clk = ~clk;

  reconf_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .upd_done(upd_done), .upd_page(upd_page),
    .wdog_err(wdog_err), .page_sel(page_sel), .reconf_n(reconf_n), .busy(busy)
  );

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_page  = 1;
      m_phase = 0;
    end else if (m_phase == 0) begin
      if (wdog_err) begin m_page = 0; m_phase = 1; end
      else if (upd_done) begin m_page = upd_page; m_phase = 1; end
    end else if (m_phase == 5) begin
      m_phase = 0;
    end else begin
      m_phase = m_phase + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      check(page_sel, m_page, "R2/R3/R5 page_sel model");
      check(reconf_n, (m_phase >= 2) ? 0 : 1, "R4 reconf_n model");
      check(busy, (m_phase != 0) ? 1 : 0, "R8 busy model");
      if (!reconf_n) lows++;
    end
  end

  task automatic request(input bit u, input bit w, input logic [2:0] pg);
    @(negedge clk);
    upd_done = u; wdog_err = w; upd_page = pg;
    @(negedge clk);
    upd_done = 1'b0; wdog_err = 1'b0;
  endtask

  task automatic idle_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(page_sel, 1, "R1 page in reset");
    check(reconf_n, 1, "R1 reconf_n in reset");
    check(busy, 0, "R1 busy in reset");
    check(page_sel, 1, "R7 INIT_PAGE default");
    rst_n = 1'b1;
    cmp_on = 1'b1;
    idle_wait(3);
    check(page_sel, 1, "R1 page after reset");

    lows = 0;
    request(1'b1, 1'b0, 3'd5);
    check(page_sel, 5, "R2 new page");
    check(reconf_n, 1, "R4 setup cycle high");
    check(busy, 1, "R8 busy on accept");
    @(negedge clk);
    check(reconf_n, 0, "R4 pulse starts");
    upd_done = 1'b1; upd_page = 3'd3;
    @(negedge clk);
    upd_done = 1'b0;
    wdog_err = 1'b1;
    @(negedge clk);
    wdog_err = 1'b0;
    idle_wait(4);
    check(lows, 4, "R4 pulse length");
    check(page_sel, 5, "R8 request while busy ignored");
    check(busy, 0, "R8 busy released");
    idle_wait(3);
    check(reconf_n, 1, "R8 no extra pulse");

    lows = 0;
    request(1'b0, 1'b1, 3'd6);
    check(page_sel, 0, "R3 recovery page");
    check(page_sel, 0, "R7 RECOVERY_PAGE default");
    idle_wait(6);
    check(lows, 4, "R4 pulse length after watchdog");

    request(1'b1, 1'b0, 3'd7);
    idle_wait(6);
    check(page_sel, 7, "R2 page 7");

    request(1'b1, 1'b1, 3'd6);
    check(page_sel, 0, "R6 watchdog wins");
    idle_wait(6);

    @(negedge clk);
    upd_done = 1'b1; upd_page = 3'd2;
    repeat (7) @(negedge clk);
    upd_done = 1'b0;
    check(page_sel, 2, "R5 page held while request stays high");
    idle_wait(10);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule